// File: doc/BRIEF.md
# EEPROM Program Sequencer

This block runs the internal programming operations of a small nonvolatile word array, here modelled as a register array of 64 words of 16 bits. A front end that has already decoded and authorised a command hands it over in a single cycle. The hand-off carries an operation type, a word address and a data word. The sequencer then runs the operation over a fixed, self-timed interval. It needs no further input during that interval, and it signals busy from the accepting cycle until the last array update.

There are four operations. Two act on one word (erase, write) and two act on the whole array (erase all, write all). Each write is split into an erase phase followed by a program phase, and each phase takes half of that operation's interval. The array changes only at the end of a phase. A one-cycle update strobe marks every change. A read port shows the array contents at any time, and a standby output tells the front end when it may power down.

Top module: `eep_prog_seq`

## Requirements
- R1: After reset the block is idle: `busy_o` is 0, `standby_o` is 1, `upd_o` is 0, and every word reads 0xFFFF on the read port.
- R2: A command is accepted when `cmd_valid_i` is 1 at a clock edge while idle. `busy_o` is 1 from the next cycle. The `cmd_op_i` codes are 2'b00 erase word, 2'b01 write word, 2'b10 erase all and 2'b11 write all.
- R3: Erase word sets the addressed word to 0xFFFF, leaves all other words unchanged, and keeps `busy_o` high for exactly T_WORD cycles.
- R4: Write word first erases the addressed word, which reads 0xFFFF from cycle T_WORD/2 (rounded down) after acceptance. It then holds the supplied data when `busy_o` falls, exactly T_WORD cycles after acceptance.
- R5: Erase all sets every word to 0xFFFF in one update at the end of a T_ERAL-cycle busy interval. Before that update the contents are unchanged.
- R6: Write all first sets every word to 0xFFFF at T_WRAL/2 (rounded down) cycles. It then sets every word to the supplied data when `busy_o` falls after T_WRAL cycles.
- R7: While busy, `cmd_valid_i` and all command inputs are ignored. The running operation keeps its duration and result, and the array shows no trace of the ignored command.
- R8: `standby_o` is 1 exactly when `busy_o` is 0.
- R9: `upd_o` is 1 for one cycle before each clock edge at which the array changes: once for an erase or an erase all, twice for a write or a write all. It is 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | One-cycle command strobe |
| cmd_op_i | input | 2 | Operation code |
| cmd_addr_i | input | 6 | Word address for single-word operations |
| cmd_data_i | input | 16 | Data for write operations |
| rd_addr_i | input | 6 | Read port address |
| rd_data_o | output | 16 | Array word at `rd_addr_i` (combinational) |
| busy_o | output | 1 | Operation in progress |
| standby_o | output | 1 | Idle; front end may enter standby |
| upd_o | output | 1 | Array updates at the coming edge |

## Verification
The assertions take for granted that the reset is released synchronously to the clock and that every duration parameter is at least 2, so each half phase lasts at least one cycle. They also assume that command inputs are sampled only at rising edges. The stimulus changes every input at the falling edge, so all of them are stable around the rising edge. During busy intervals it sends extra commands on purpose, to show that they are dropped. The bench runs with short durations so that many random operations fit in the run.

// File: rtl/eep_prog_pkg.sv
package eep_prog_pkg;

  typedef enum logic [1:0] {
    OP_ERASE_WORD = 2'b00,
    OP_WRITE_WORD = 2'b01,
    OP_ERASE_ALL  = 2'b10,
    OP_WRITE_ALL  = 2'b11
  } eep_op_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'b00,
    PH_ERASE = 2'b01,
    PH_PROG  = 2'b10
  } eep_phase_e;

  function automatic logic op_has_prog(eep_op_e op);
    return (op == OP_WRITE_WORD) || (op == OP_WRITE_ALL);
  endfunction

  function automatic logic op_is_bulk(eep_op_e op);
    return (op == OP_ERASE_ALL) || (op == OP_WRITE_ALL);
  endfunction

endpackage

// File: rtl/eep_phase_timer.sv
module eep_phase_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= len_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - CNT_W'(1);
  end

  // last cycle of the phase
  assign done_o = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/eep_word_array.sv
module eep_word_array #(
  parameter int unsigned AW = 6,
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          all_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    logic sel;
    assign sel = we_i && (all_i || (waddr_i == AW'(i)));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  mem_q[i] <= '1;
      else if (sel) mem_q[i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/eep_seq_fsm.sv
module eep_seq_fsm
  import eep_prog_pkg::*;
#(
  parameter int unsigned AW             = 6,
  parameter int unsigned DW             = 16,
  parameter int unsigned CNT_W          = 8,
  parameter int unsigned ERW_LEN        = 4,
  parameter int unsigned WRW_ERASE_LEN  = 2,
  parameter int unsigned WRW_PROG_LEN   = 2,
  parameter int unsigned ERAL_LEN       = 6,
  parameter int unsigned WRAL_ERASE_LEN = 4,
  parameter int unsigned WRAL_PROG_LEN  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  eep_op_e          cmd_op_i,
  input  logic [AW-1:0]    cmd_addr_i,
  input  logic [DW-1:0]    cmd_data_i,
  input  logic             phase_done_i,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_len_o,
  output logic             arr_we_o,
  output logic             arr_all_o,
  output logic [AW-1:0]    arr_addr_o,
  output logic [DW-1:0]    arr_wdata_o,
  output logic             busy_o,
  output eep_op_e          op_o
);

  eep_phase_e    ph_q, ph_d;
  eep_op_e       op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          accept, erase_end, prog_end;

  function automatic logic [CNT_W-1:0] first_len(eep_op_e op);
    case (op)
      OP_ERASE_WORD: return CNT_W'(ERW_LEN);
      OP_WRITE_WORD: return CNT_W'(WRW_ERASE_LEN);
      OP_ERASE_ALL:  return CNT_W'(ERAL_LEN);
      default:       return CNT_W'(WRAL_ERASE_LEN);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] second_len(eep_op_e op);
    return (op == OP_WRITE_ALL) ? CNT_W'(WRAL_PROG_LEN) : CNT_W'(WRW_PROG_LEN);
  endfunction

  assign accept    = cmd_valid_i && (ph_q == PH_IDLE);
  assign erase_end = (ph_q == PH_ERASE) && phase_done_i;
  assign prog_end  = (ph_q == PH_PROG) && phase_done_i;

  always_comb begin
    ph_d = ph_q;
    if (accept)         ph_d = PH_ERASE;
    else if (erase_end) ph_d = op_has_prog(op_q) ? PH_PROG : PH_IDLE;
    else if (prog_end)  ph_d = PH_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      op_q   <= OP_ERASE_WORD;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      ph_q <= ph_d;
      if (accept) begin
        op_q   <= cmd_op_i;
        addr_q <= cmd_addr_i;
        data_q <= cmd_data_i;
      end
    end
  end

  assign tmr_load_o  = accept || (erase_end && op_has_prog(op_q));
  assign tmr_len_o   = accept ? first_len(cmd_op_i) : second_len(op_q);

  assign arr_we_o    = erase_end || prog_end;
  assign arr_all_o   = op_is_bulk(op_q);
  assign arr_addr_o  = addr_q;
  assign arr_wdata_o = (ph_q == PH_PROG) ? data_q : '1;

  assign busy_o      = (ph_q != PH_IDLE);
  assign op_o        = op_q;

endmodule

// File: rtl/eep_prog_seq.sv
module eep_prog_seq
  import eep_prog_pkg::*;
#(
  parameter int unsigned AW     = 6,
  parameter int unsigned DW     = 16,
  parameter int unsigned T_WORD = 100000,
  parameter int unsigned T_ERAL = 300000,
  parameter int unsigned T_WRAL = 750000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  input  logic [1:0]    cmd_op_i,
  input  logic [AW-1:0] cmd_addr_i,
  input  logic [DW-1:0] cmd_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  output logic          busy_o,
  output logic          standby_o,
  output logic          upd_o
);

  localparam int unsigned W_HALF = T_WORD / 2;
  localparam int unsigned W_REST = T_WORD - W_HALF;
  localparam int unsigned A_HALF = T_WRAL / 2;
  localparam int unsigned A_REST = T_WRAL - A_HALF;
  localparam int unsigned T_MAX  = (T_WORD > T_ERAL) ?
                                   ((T_WORD > T_WRAL) ? T_WORD : T_WRAL) :
                                   ((T_ERAL > T_WRAL) ? T_ERAL : T_WRAL);
  localparam int unsigned CNT_W  = $clog2(T_MAX + 1);

  logic             tmr_load, tmr_done;
  logic [CNT_W-1:0] tmr_len;
  logic             arr_we, arr_all;
  logic [AW-1:0]    arr_addr;
  logic [DW-1:0]    arr_wdata;
  logic             busy;
  eep_op_e          op_cur;
  logic [1:0]       op_q;

  eep_seq_fsm #(
    .AW(AW), .DW(DW), .CNT_W(CNT_W),
    .ERW_LEN(T_WORD), .WRW_ERASE_LEN(W_HALF), .WRW_PROG_LEN(W_REST),
    .ERAL_LEN(T_ERAL), .WRAL_ERASE_LEN(A_HALF), .WRAL_PROG_LEN(A_REST)
  ) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_valid_i  (cmd_valid_i),
    .cmd_op_i     (eep_op_e'(cmd_op_i)),
    .cmd_addr_i   (cmd_addr_i),
    .cmd_data_i   (cmd_data_i),
    .phase_done_i (tmr_done),
    .tmr_load_o   (tmr_load),
    .tmr_len_o    (tmr_len),
    .arr_we_o     (arr_we),
    .arr_all_o    (arr_all),
    .arr_addr_o   (arr_addr),
    .arr_wdata_o  (arr_wdata),
    .busy_o       (busy),
    .op_o         (op_cur)
  );

  eep_phase_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .len_i  (tmr_len),
    .done_o (tmr_done)
  );

  eep_word_array #(.AW(AW), .DW(DW)) u_arr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (arr_we),
    .all_i   (arr_all),
    .waddr_i (arr_addr),
    .wdata_i (arr_wdata),
    .raddr_i (rd_addr_i),
    .rdata_o (rd_data_o)
  );

  assign op_q      = op_cur;
  assign busy_o    = busy;
  assign standby_o = !busy;
  assign upd_o     = arr_we;

endmodule

// File: rtl/eep_prog_seq_chk.sv
module eep_prog_seq_chk #(
  parameter int unsigned T_WORD = 100000,
  parameter int unsigned T_ERAL = 300000,
  parameter int unsigned T_WRAL = 750000
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cmd_valid_i,
  input logic       busy_o,
  input logic       standby_o,
  input logic       upd_o,
  input logic [1:0] op_q
);

  logic [31:0] busy_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      busy_cnt <= '0;
    else if (!busy_o) busy_cnt <= '0;
    else              busy_cnt <= busy_cnt + 32'd1;
  end

  function automatic logic [31:0] op_len(logic [1:0] op);
    case (op)
      2'b00, 2'b01: return 32'(T_WORD);
      2'b10:        return 32'(T_ERAL);
      default:      return 32'(T_WRAL);
    endcase
  endfunction

  a_r2_accept_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !busy_o) |=> busy_o);

  a_r7_busy_ignore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && busy_o) |=> $stable(op_q));

  a_r8_standby_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_o |-> (!busy_o && !upd_o));

  a_r9_upd_in_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |-> busy_o);

  a_r9_end_with_upd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(upd_o));

  // R3 R5 R6: busy interval length per operation class
  a_r5_duration: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> ($past(busy_cnt) == op_len(op_q) - 32'd1));

endmodule

bind eep_prog_seq eep_prog_seq_chk #(
  .T_WORD(T_WORD), .T_ERAL(T_ERAL), .T_WRAL(T_WRAL)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .busy_o      (busy_o),
  .standby_o   (standby_o),
  .upd_o       (upd_o),
  .op_q        (op_q)
);

// File: tb/eep_prog_seq_bench.sv
module eep_prog_seq_bench;

  localparam int AW     = 6;
  localparam int DW     = 16;
  localparam int DEPTH  = 1 << AW;
  localparam int T_WORD = 8;
  localparam int T_ERAL = 12;
  localparam int T_WRAL = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [1:0]    cmd_op = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          busy, standby, upd;

  int checks = 0;
  int fails  = 0;
  logic [DW-1:0] ref_mem [DEPTH];

  always #10 clk = ~clk;

  eep_prog_seq #(
    .AW(AW), .DW(DW), .T_WORD(T_WORD), .T_ERAL(T_ERAL), .T_WRAL(T_WRAL)
  ) u_eep_prog_seq (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_addr_i(cmd_addr), .cmd_data_i(cmd_data), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .busy_o(busy), .standby_o(standby), .upd_o(upd)
  );

  function automatic int exp_len(logic [1:0] op);
    return (op == 2'b10) ? T_ERAL : (op == 2'b11) ? T_WRAL : T_WORD;
  endfunction

  function automatic string op_req(logic [1:0] op);
    case (op)
      2'b00:   return "R3";
      2'b01:   return "R4";
      2'b10:   return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic read_word(input int a, output logic [DW-1:0] d);
    rd_addr = AW'(a);
    #1;
    d = rd_data;
  endtask

  task automatic compare_all(input string req);
    logic [DW-1:0] d;
    int bad = 0;
    int first_a = -1;
    for (int a = 0; a < DEPTH; a++) begin
      read_word(a, d);
      if (d !== ref_mem[a]) begin
        bad++;
        if (first_a < 0) first_a = a;
      end
    end
    check(bad == 0, req, bad, 0);
    if (first_a >= 0) begin
      read_word(first_a, d);
      check(1'b0, req, int'(d), int'(ref_mem[first_a]));
    end
  endtask

  function automatic void apply_ref(logic [1:0] op, logic [AW-1:0] a, logic [DW-1:0] d);
    case (op)
      2'b00: ref_mem[a] = '1;
      2'b01: ref_mem[a] = d;
      2'b10: for (int i = 0; i < DEPTH; i++) ref_mem[i] = '1;
      default: for (int i = 0; i < DEPTH; i++) ref_mem[i] = d;
    endcase
  endfunction

  // issue at negedge; returns after the strobe edge
  task automatic issue(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_op = 2'(($urandom)); cmd_addr = AW'($urandom); cmd_data = DW'($urandom);
  endtask

  task automatic run_op(input logic [1:0] op, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input bit inject);
    int n = 0;
    int upds = 0;
    bit sb_bad = 0;
    issue(op, a, d);
    check(busy === 1'b1, "R2", int'(busy), 1);
    while (busy === 1'b1 && n < 1000) begin
      if (standby !== 1'b0) sb_bad = 1;
      if (upd === 1'b1) upds++;
      if (inject && n == 2) begin
        cmd_valid = 1'b1; cmd_op = 2'($urandom); cmd_addr = AW'($urandom);
        cmd_data = DW'($urandom);
      end
      @(negedge clk);
      if (inject && n == 2) cmd_valid = 1'b0;
      n++;
    end
    check(n == exp_len(op), inject ? "R7" : op_req(op), n, exp_len(op));
    check(!sb_bad && standby === 1'b1, "R8", int'(sb_bad), 0);
    check(upds == (op[0] ? 2 : 1), "R9", upds, op[0] ? 2 : 1);
    apply_ref(op, a, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    logic [DW-1:0] d;
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(busy === 1'b0 && standby === 1'b1 && upd === 1'b0, "R1",
          {busy, standby, upd}, 3'b010);
    compare_all("R1");

    // R4 directed: erase phase visible mid-way, then data
    run_op(2'b11, '0, 16'h1234, 1'b0);
    compare_all("R6");
    issue(2'b01, 6'd5, 16'hA5C3);
    repeat (T_WORD / 2 - 1) @(negedge clk);
    read_word(5, d);
    check(d === 16'h1234, "R4", int'(d), 16'h1234);
    check(upd === 1'b1, "R9", int'(upd), 1);
    @(negedge clk);
    read_word(5, d);
    check(d === 16'hFFFF, "R4", int'(d), 16'hFFFF);
    check(upd === 1'b0, "R9", int'(upd), 0);
    repeat (T_WORD - T_WORD / 2) @(negedge clk);
    read_word(5, d);
    check(busy === 1'b0 && d === 16'hA5C3, "R4", int'(d), 16'hA5C3);
    apply_ref(2'b01, 6'd5, 16'hA5C3);
    compare_all("R4");

    // R6 directed: whole array erased at half time
    issue(2'b11, '0, 16'h0F0F);
    repeat (T_WRAL / 2 - 1) @(negedge clk);
    read_word(5, d);
    check(d === 16'hA5C3, "R6", int'(d), 16'hA5C3);
    @(negedge clk);
    read_word(63, d);
    check(d === 16'hFFFF, "R6", int'(d), 16'hFFFF);
    while (busy === 1'b1) @(negedge clk);
    apply_ref(2'b11, '0, 16'h0F0F);
    compare_all("R6");

    // R5 directed: unchanged until the end
    issue(2'b10, '0, '0);
    repeat (T_ERAL - 1) @(negedge clk);
    read_word(7, d);
    check(d === 16'h0F0F, "R5", int'(d), 16'h0F0F);
    @(negedge clk);
    apply_ref(2'b10, '0, '0);
    compare_all("R5");

    // R3 boundaries: first and last word
    run_op(2'b01, 6'd0, 16'h0000, 1'b0);
    run_op(2'b01, 6'd63, 16'h8001, 1'b0);
    run_op(2'b00, 6'd63, '0, 1'b0);
    compare_all("R3");

    // R7 directed: erase word with a command injected while busy
    run_op(2'b00, 6'd0, '0, 1'b1);
    compare_all("R7");

    // random mix
    for (int k = 0; k < 40; k++) begin
      logic [1:0] op;
      op = 2'($urandom);
      run_op(op, AW'($urandom), DW'($urandom), ($urandom % 3) == 0);
      if (k % 8 == 7) compare_all(op_req(op));
    end
    compare_all("R7");

    finish_run();
  end

endmodule